// File: doc/BRIEF.md
# Fuse Map Store with Readback Security

This block keeps the configuration bits of a small programmable logic array in one linear bit address space. Fuses 0 to 5827 configure the logic; fuses 5828 to 5891 form a 64-bit user signature. The fuses sit in 32-bit words: bit i of word w is fuse 32*w+i. A program cycle always begins with an automatic erase of every word to all ones. After the erase the store accepts a stream of load beats, either one fuse per beat (serial) or one word per beat. A stream may stop at any fuse count. The short map of 5828 fuses is accepted and leaves the signature erased. The extended map of 5892 fuses is also accepted.

After programming, the owner can set a one-bit security flag. While the flag is set, a word read returns zeros in every functional position, and a denied flag is raised for that read. Signature positions are returned as they are. The flag can be cleared only by starting a new program cycle, which erases the store. The twenty per-cell mode bits, fuses 5808 to 5827, are always driven to the logic fabric.

Top module: `fuse_store`

## Requirements
- R1: After reset every fuse reads as 1 and the security flag is clear. busy, rd_data and rd_denied are 0.
- R2: prog_start while idle erases all fuses to 1 and clears the security flag. busy rises the cycle after and stays high for the 185-cycle erase and then for the load. Load beats presented during the erase are ignored.
- R3: In serial mode (prog_serial=1 at start), each beat writes ld_data[0] to the next fuse address, starting at fuse 0.
- R4: In word mode (prog_serial=0 at start), each beat writes the low ld_len bits of ld_data into the next word, starting at word 0. Higher bits of that word keep their value.
- R5: A load ends on any of three events: ld_done; a word beat with ld_len below 32; or the fuse pointer reaching 5892. busy is low in the cycle after the ending edge. Beats while idle are ignored.
- R6: A 5828-fuse load leaves every signature fuse at 1. A 5892-fuse load sets the signature to the loaded bits.
- R7: A read with rd_en high while idle returns word rd_addr in rd_data one cycle later. Bits above fuse 5891, and words beyond 184, read as 0. In a cycle with no read, rd_data is 0.
- R8: sec_set while idle sets the security flag. While the flag is set, a read returns 0 in functional positions. rd_denied is high for exactly the cycle of that result when the word holds any functional fuse.
- R9: Signature positions read back unchanged whatever the state of the security flag. A word that holds only signature fuses never raises rd_denied.
- R10: The security flag stays set until the next prog_start. sec_set during a program cycle is ignored.
- R11: cell_mode[2k] is fuse 5808+2k and cell_mode[2k+1] is fuse 5809+2k, for cells k=0..9. These bits are valid regardless of the security flag.
- R12: A read requested while busy returns rd_data 0 with rd_denied 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Start a program cycle (erase, then load) |
| prog_serial | input | 1 | Load format for the cycle: 1 = one fuse per beat, 0 = one word per beat |
| ld_vld | input | 1 | Load beat valid |
| ld_data | input | 32 | Beat data (bit 0 only in serial mode) |
| ld_len | input | 6 | Valid low bits of a word beat, 0 to 32 |
| ld_done | input | 1 | End the load |
| sec_set | input | 1 | Set the security flag |
| rd_en | input | 1 | Word read request |
| rd_addr | input | 8 | Word address of the read |
| busy | output | 1 | Erase or load in progress |
| rd_data | output | 32 | Read result, registered |
| rd_denied | output | 1 | Read touched functional fuses while secured |
| cell_mode | output | 20 | Mode bit pairs of the ten cells |

## Verification
The load path is tried with a short serial stream ended by ld_done. The serial bit pattern is not word aligned, so errors in bit-pointer stepping and word-boundary crossing show up. A 5828-fuse word stream ending on a partial beat separates the masked partial write from a whole-word write, because the signature must stay erased. A full 5892-fuse stream ends on the pointer limit and proves the signature can be written. Reads are taken before and after securing on a pure functional word, on the mixed word 182 and on pure signature words. These three cases tell apart a per-bit mask, a whole-word block and no block at all. Further reads and sec_set pulses placed during erase and load show that neither has any effect while busy.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_LOAD  = 2'd2
  } fz_state_e;

  // number of storage words needed for nbits fuses
  function automatic int fz_words(input int nbits, input int w);
    return (nbits + w - 1) / w;
  endfunction
endpackage

// File: rtl/fuse_ctrl.sv
module fuse_ctrl import fuse_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int TOTAL  = 5892,
  parameter int DEPTH  = 185,
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              prog_serial,
  input  logic              ld_vld,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [LW-1:0]     ld_len,
  input  logic              ld_done,
  input  logic              sec_set,
  output logic              busy,
  output logic              secure,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [WORD_W-1:0] wr_mask,
  output logic [WORD_W-1:0] wr_data
);
  localparam int PW = $clog2(TOTAL + WORD_W + 1);
  localparam int OW = $clog2(WORD_W);

  function automatic logic [WORD_W-1:0] low_ones(input logic [LW-1:0] n);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  fz_state_e     st;
  logic [IW-1:0] eidx;
  logic [PW-1:0] ptr, ptr_nxt;
  logic          ser_q;
  logic          beat, erase_done, load_end;

  assign beat       = (st == ST_LOAD) && ld_vld;
  assign ptr_nxt    = ser_q ? ptr + PW'(1) : ptr + PW'(WORD_W);
  assign erase_done = (st == ST_ERASE) && (eidx == IW'(DEPTH - 1));
  assign load_end   = (st == ST_LOAD) &&
                      (ld_done || (beat && ((!ser_q && ld_len < LW'(WORD_W)) ||
                                            ptr_nxt >= PW'(TOTAL))));
  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      eidx   <= '0;
      ptr    <= '0;
      ser_q  <= 1'b0;
      secure <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (prog_start) begin
            st     <= ST_ERASE;
            eidx   <= '0;
            ser_q  <= prog_serial;
            secure <= 1'b0;
          end else if (sec_set) begin
            secure <= 1'b1;
          end
        end
        ST_ERASE: begin
          eidx <= eidx + IW'(1);
          if (erase_done) begin
            st  <= ST_LOAD;
            ptr <= '0;
          end
        end
        ST_LOAD: begin
          if (load_end) st <= ST_IDLE;
          else if (beat) ptr <= ptr_nxt;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = IW'(ptr >> OW);
    wr_mask = '0;
    wr_data = '0;
    if (st == ST_ERASE) begin
      wr_en   = 1'b1;
      wr_idx  = eidx;
      wr_mask = '1;
      wr_data = '1;
    end else if (beat) begin
      wr_en = 1'b1;
      if (ser_q) begin
        wr_mask = WORD_W'(1) << ptr[OW-1:0];
        wr_data = {WORD_W{ld_data[0]}};
      end else begin
        wr_mask = low_ones(ld_len);
        wr_data = ld_data;
      end
    end
  end
endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 185,
  parameter int MODE_BASE = 5808,
  parameter int CELLS     = 10,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [WORD_W-1:0]  wr_mask,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic [2*CELLS-1:0] cell_mode
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_idx] <= (mem[wr_idx] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  assign rd_word = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

  for (genvar k = 0; k < 2 * CELLS; k++) begin : g_tap
    localparam int A = MODE_BASE + k;
    assign cell_mode[k] = mem[A / WORD_W][A % WORD_W];
  end
endmodule

// File: rtl/fuse_rdport.sv
module fuse_rdport #(
  parameter int WORD_W = 32,
  parameter int FUNC   = 5828,
  parameter int TOTAL  = 5892,
  parameter int IW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              idle,
  input  logic              secure,
  input  logic [IW-1:0]     rd_idx,
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_denied
);
  // bits of word w whose fuse address lies below lim
  function automatic logic [WORD_W-1:0] span_mask(input int w, input int lim);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (w * WORD_W + i) < lim;
    return m;
  endfunction

  logic [WORD_W-1:0] valid_m, func_m, shown;
  logic              blocked;

  assign valid_m = span_mask(int'(rd_idx), TOTAL);
  assign func_m  = span_mask(int'(rd_idx), FUNC);
  assign blocked = secure && (|func_m);
  assign shown   = raw_word & valid_m & (secure ? ~func_m : '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_denied <= 1'b0;
    end else if (rd_en && idle) begin
      rd_data   <= shown;
      rd_denied <= blocked;
    end else begin
      rd_data   <= '0;
      rd_denied <= 1'b0;
    end
  end
endmodule

// File: rtl/fuse_store.sv
module fuse_store import fuse_pkg::*; #(
  parameter int WORD_W     = 32,
  parameter int FUNC_FUSES = 5828,
  parameter int SIG_FUSES  = 64,
  parameter int CELLS      = 10,
  localparam int TOTAL = FUNC_FUSES + SIG_FUSES,
  localparam int DEPTH = fz_words(TOTAL, WORD_W),
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(WORD_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_start,
  input  logic               prog_serial,
  input  logic               ld_vld,
  input  logic [WORD_W-1:0]  ld_data,
  input  logic [LW-1:0]      ld_len,
  input  logic               ld_done,
  input  logic               sec_set,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic               busy,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_denied,
  output logic [2*CELLS-1:0] cell_mode
);
  logic              secure, idle, wr_en;
  logic [AW-1:0]     wr_idx;
  logic [WORD_W-1:0] wr_mask, wr_data, raw_word;

  assign idle = !busy;

  fuse_ctrl #(.WORD_W(WORD_W), .TOTAL(TOTAL), .DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_serial(prog_serial),
    .ld_vld(ld_vld), .ld_data(ld_data), .ld_len(ld_len), .ld_done(ld_done),
    .sec_set(sec_set), .busy(busy), .secure(secure), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  fuse_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .MODE_BASE(FUNC_FUSES - 2 * CELLS),
               .CELLS(CELLS)) i_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_idx(rd_addr), .rd_word(raw_word), .cell_mode(cell_mode)
  );

  fuse_rdport #(.WORD_W(WORD_W), .FUNC(FUNC_FUSES), .TOTAL(TOTAL), .IW(AW)) i_rdport (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .idle(idle), .secure(secure),
    .rd_idx(rd_addr), .raw_word(raw_word), .rd_data(rd_data), .rd_denied(rd_denied)
  );
endmodule

// File: rtl/fuse_store_chk.sv
module fuse_store_chk #(
  parameter int WORD_W = 32,
  parameter int CELLS  = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               prog_start,
  input logic               sec_set,
  input logic               rd_en,
  input logic               busy,
  input logic               secure,
  input logic [WORD_W-1:0]  rd_data,
  input logic               rd_denied,
  input logic [2*CELLS-1:0] cell_mode
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prog_start) |=> busy);

  // R12
  busy_read_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rd_data == '0 && !rd_denied));

  // R7
  no_read_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0 && !rd_denied));

  // R8
  deny_needs_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_denied |-> ($past(secure) && $past(rd_en)));

  // R10
  secure_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(prog_start));

  // R10
  secure_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure) |-> ($past(sec_set) && !$past(busy)));

  // R11
  mode_stable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cell_mode));
endmodule

bind fuse_store fuse_store_chk #(.WORD_W(WORD_W), .CELLS(CELLS)) i_chk (
  .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .sec_set(sec_set),
  .rd_en(rd_en), .busy(busy), .secure(secure), .rd_data(rd_data),
  .rd_denied(rd_denied), .cell_mode(cell_mode)
);

// File: tb/test_fuse_store.sv
module test_fuse_store;
  localparam int TOT = 5892;
  localparam int FN  = 5828;
  localparam int DP  = 185;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        prog_start = 0, prog_serial = 0, ld_vld = 0, ld_done = 0, sec_set = 0, rd_en = 0;
  logic [31:0] ld_data = '0;
  logic [5:0]  ld_len = '0;
  logic [7:0]  rd_addr = '0;
  logic        busy, rd_denied;
  logic [31:0] rd_data;
  logic [19:0] cell_mode;

  fuse_store i_fuse_store (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_serial(prog_serial),
    .ld_vld(ld_vld), .ld_data(ld_data), .ld_len(ld_len), .ld_done(ld_done),
    .sec_set(sec_set), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
    .rd_data(rd_data), .rd_denied(rd_denied), .cell_mode(cell_mode)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit running = 0, reported = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mdl [DP];
  int          m_st, m_cnt, m_ptr;
  bit          m_ser, m_sec, m_dn;
  logic [31:0] m_rd;

  function automatic logic mget(input int a);
    return mdl[a / 32][a % 32];
  endfunction

  function automatic logic [19:0] m_cells();
    logic [19:0] c;
    for (int k = 0; k < 20; k++) c[k] = mget(FN - 20 + k);
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sec = 0; m_rd = '0; m_dn = 0; m_ptr = 0; m_cnt = 0; m_ser = 0;
      for (int w = 0; w < DP; w++) mdl[w] = '1;
    end else begin
      bit fin;
      if (rd_en && m_st == 0) begin
        logic [31:0] rv;
        rv = '0;
        for (int i = 0; i < 32; i++) begin
          int a;
          a = int'(rd_addr) * 32 + i;
          if (a < TOT && (!m_sec || a >= FN)) rv[i] = mget(a);
        end
        m_rd = rv;
        m_dn = m_sec && (int'(rd_addr) * 32 < FN);
      end else begin
        m_rd = '0; m_dn = 0;
      end
      case (m_st)
        0: if (prog_start) begin
             m_st = 1; m_cnt = 0; m_ser = prog_serial; m_sec = 0;
             for (int w = 0; w < DP; w++) mdl[w] = '1;
           end else if (sec_set) m_sec = 1;
        1: begin
             m_cnt++;
             if (m_cnt == DP) begin m_st = 2; m_ptr = 0; end
           end
        default: begin
          fin = ld_done;
          if (ld_vld) begin
            if (m_ser) begin
              mdl[m_ptr / 32][m_ptr % 32] = ld_data[0];
              m_ptr++;
            end else begin
              for (int i = 0; i < int'(ld_len); i++)
                if (m_ptr + i < TOT) mdl[(m_ptr + i) / 32][(m_ptr + i) % 32] = ld_data[i];
              if (int'(ld_len) < 32) fin = 1;
              m_ptr += 32;
            end
            if (m_ptr >= TOT) fin = 1;
          end
          if (fin) m_st = 0;
        end
      endcase
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      chk("R2 busy", 64'(busy), 64'(m_st != 0));
      chk("R7 rd_data", 64'(rd_data), 64'(m_rd));
      chk("R8 rd_denied", 64'(rd_denied), 64'(m_dn));
      if (m_st == 0) chk("R11 cell_mode", 64'(cell_mode), 64'(m_cells()));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] pat(input int i);
    return 32'(32'h9E37_79B9 * (i + 1));
  endfunction

  task automatic rd(input int a, output logic [31:0] d, output logic dn);
    rd_en = 1; rd_addr = 8'(a);
    @(negedge clk);
    rd_en = 0;
    d = rd_data; dn = rd_denied;
  endtask

  task automatic beat(input logic [31:0] d, input int len);
    ld_vld = 1; ld_data = d; ld_len = 6'(len);
    @(negedge clk);
    ld_vld = 0;
  endtask

  task automatic start(input bit ser);
    prog_start = 1; prog_serial = ser;
    @(negedge clk);
    prog_start = 0;
  endtask

  task automatic wait_load();
    while (m_st != 2) @(negedge clk);
  endtask

  task automatic pulse_sec();
    sec_set = 1;
    @(negedge clk);
    sec_set = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    logic        dn;
    logic [19:0] cm0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 rd_data", 64'(rd_data), 0);
    rd(0, d, dn);
    chk("R1 erased word0", 64'(d), 64'(32'hFFFF_FFFF));
    chk("R1 not secured", 64'(dn), 0);
    rd(184, d, dn);
    chk("R7 tail bits zero", 64'(d), 64'(32'h0000_000F));
    rd(200, d, dn);
    chk("R7 out of range", 64'(d), 0);

    // serial load of 40 fuses, one beat sent during erase
    start(1'b1);
    chk("R2 busy after start", 64'(busy), 1);
    beat(32'h0, 1);
    wait_load();
    for (int i = 0; i < 40; i++) beat(32'((i % 3) == 0), 1);
    ld_done = 1; @(negedge clk); ld_done = 0;
    chk("R5 done clears busy", 64'(busy), 0);
    beat(32'h0, 1);
    rd(0, d, dn);
    for (int i = 0; i < 32; i++) e[i] = ((i % 3) == 0);
    chk("R3 serial word0", 64'(d), 64'(e));
    chk("R2 erase beat ignored", 64'(d[0]), 1);
    rd(1, d, dn);
    e = '1;
    for (int i = 0; i < 8; i++) e[i] = (((32 + i) % 3) == 0);
    chk("R3 serial word1", 64'(d), 64'(e));

    // short word map 5828 fuses
    start(1'b0);
    wait_load();
    for (int i = 0; i < 182; i++) beat(pat(i), 32);
    beat(32'hFFFF_FFF6 & 32'h6, 4);
    chk("R5 partial beat ends load", 64'(busy), 0);
    rd(5, d, dn);
    chk("R4 word5", 64'(d), 64'(pat(5)));
    rd(182, d, dn);
    chk("R4 partial masked", 64'(d), 64'(32'hFFFF_FFF6));
    rd(183, d, dn);
    chk("R6 signature erased", 64'(d), 64'(32'hFFFF_FFFF));
    e = pat(181);
    chk("R11 cell bits", 64'(cell_mode), 64'({4'h6, e[31:16]}));
    cm0 = cell_mode;

    // secure
    pulse_sec();
    rd(0, d, dn);
    chk("R8 secured data", 64'(d), 0);
    chk("R8 secured denied", 64'(dn), 1);
    @(negedge clk);
    chk("R8 denied one cycle", 64'(rd_denied), 0);
    rd(182, d, dn);
    chk("R9 mixed word", 64'(d), 64'(32'hFFFF_FFF0));
    chk("R8 mixed denied", 64'(dn), 1);
    rd(183, d, dn);
    chk("R9 signature readable", 64'(d), 64'(32'hFFFF_FFFF));
    chk("R9 no denied", 64'(dn), 0);
    chk("R11 cells under security", 64'(cell_mode), 64'(cm0));
    repeat (5) @(negedge clk);
    rd(3, d, dn);
    chk("R10 still secured", 64'(dn), 1);

    // extended map; sec_set and read during the cycle
    start(1'b0);
    pulse_sec();
    wait_load();
    rd(0, d, dn);
    chk("R12 busy read data", 64'(d), 0);
    chk("R12 busy read denied", 64'(dn), 0);
    for (int i = 0; i < 185; i++) beat(pat(i + 7), 32);
    chk("R5 pointer limit ends load", 64'(busy), 0);
    rd(0, d, dn);
    chk("R10 cleared by program", 64'(d), 64'(pat(7)));
    chk("R10 no denied", 64'(dn), 0);
    rd(183, d, dn);
    chk("R6 signature loaded", 64'(d), 64'(pat(190)));
    rd(184, d, dn);
    chk("R7 last word masked", 64'(d), 64'(pat(191) & 32'hF));

    repeat (2) @(negedge clk);
    running = 0;
    report();
    $finish;
  end
endmodule